// File: doc/BRIEF.md
# Comparison-Free Counting Sorter

This block sorts a set of up to N = 2^DATA_W unsigned DATA_W-bit values without any magnitude comparator. Each arriving value is decoded into a one-hot select. That select bumps a per-value occurrence counter. Once every possible value has a counter, ordering follows from walking those counters by index.

A sort begins with a one-cycle `start_i`. A fixed collection window of N cycles follows, in which any cycle with `in_valid_i` high contributes one element. An emission pass then visits every possible value from 0 upward. A value that was never seen costs one cycle. A value seen once is shifted into the result array and the index moves on. A repeated value is shifted in again on each cycle while its counter is decremented and written back, with the index held until the last copy leaves.

The result array is a shift register, and the order select chooses which end new entries enter from. When the pass completes, `done_o` rises. The sorted set then stays on `sorted_o` until the next start.

Top module: `counting_sorter`

## Requirements
- R1: After reset, `done_o` is low and every entry of `sorted_o` is zero. Entry i occupies bits [i*DATA_W +: DATA_W].
- R2: `start_i` is accepted while no sort is in progress. It clears all occurrence counts and all result entries, and it drops `done_o` on the same clock edge.
- R3: The collection window is exactly the N cycles that follow the accepting start edge. `in_valid_i` is ignored outside that window, both before a start and during the emission pass.
- R4: With ascending order selected (order bit 0), the M collected elements occupy entries N-M to N-1, non-decreasing with rising entry index, and entries 0 to N-M-1 are zero.
- R5: With descending order selected (order bit 1), the M collected elements occupy entries 0 to M-1, non-increasing with rising entry index, and entries M to N-1 are zero.
- R6: Every value appears in the result exactly as many times as it was collected, including all-equal and empty sets.
- R7: `done_o` rises exactly 2N + M - D clock edges after the accepting start edge, where D is the number of distinct collected values.
- R8: The order select is sampled on the accepting start edge. Changing `descend_i` later in the sort has no effect on that sort.
- R9: Once `done_o` is high, it and `sorted_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new sort (one-cycle pulse) |
| descend_i | input | 1 | Order select: 0 ascending, 1 descending |
| in_valid_i | input | 1 | Element present on in_data_i |
| in_data_i | input | DATA_W | Element value |
| done_o | output | 1 | Sorted result available |
| sorted_o | output | N*DATA_W | Result array, entry i at bits [i*DATA_W +: DATA_W] |

## Verification
The start is sampled on one edge, and the elements are sampled on the N edges that follow it. Results appear 2N + M - D edges after the start edge, because every empty value costs one cycle and every copy of a present value costs one cycle. The bench drives inputs on falling edges and counts rising edges from the start edge to the falling edge where `done_o` is first seen. It requires that count to equal the figure computed from its own duplicate tally. The array is compared at that same falling edge, and again three cycles later to confirm that it holds.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ, PH_DONE} phase_e;
endpackage

// File: rtl/cfs_onehot_dec.sv
module cfs_onehot_dec #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic         en_i,
  input  logic [W-1:0] code_i,
  output logic [N-1:0] hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = en_i && (code_i == W'(i));
  end
endmodule

// File: rtl/cfs_occ_bank.sv
module cfs_occ_bank #(
  parameter int W  = 3,
  parameter int CW = 10,
  localparam int N = 1 << W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [N-1:0]  inc_hot_i,
  input  logic [N-1:0]  dec_hot_i,
  input  logic [CW-1:0] dec_val_i,
  input  logic [W-1:0]  rd_idx_i,
  output logic [CW-1:0] rd_cnt_o
);
  localparam logic [CW-1:0] CntMax = '1;

  logic [CW-1:0] cnt_q [N];

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q[i] <= '0;
      else if (clear_i)                             cnt_q[i] <= '0;
      else if (inc_hot_i[i] && cnt_q[i] != CntMax)  cnt_q[i] <= cnt_q[i] + 1'b1; // saturate
      else if (dec_hot_i[i])                        cnt_q[i] <= dec_val_i;       // write-back
    end

    // R6: a full counter never wraps to zero, so no occurrence is lost
    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[i] == CntMax && !clear_i) |=> (cnt_q[i] != '0));
  end

  assign rd_cnt_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/cfs_sort_shreg.sv
module cfs_sort_shreg #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           shift_i,
  input  logic           desc_i,
  input  logic [W-1:0]   din_i,
  output logic [N*W-1:0] data_o
);
  logic [W-1:0] ent_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [W-1:0] from_lo, from_hi;
    if (i == 0) begin : g_lo_edge
      assign from_lo = din_i;
    end else begin : g_lo_mid
      assign from_lo = ent_q[i-1];
    end
    if (i == N-1) begin : g_hi_edge
      assign from_hi = din_i;
    end else begin : g_hi_mid
      assign from_hi = ent_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q[i] <= '0;
      else if (clear_i) ent_q[i] <= '0;
      else if (shift_i) ent_q[i] <= desc_i ? from_lo : from_hi;
    end

    assign data_o[i*W +: W] = ent_q[i];
  end

  assert_asc_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i && !desc_i) |=> (ent_q[N-1] == $past(din_i)));
  assert_desc_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i && desc_i) |=> (ent_q[0] == $past(din_i)));
endmodule

// File: rtl/cfs_ctrl.sv
module cfs_ctrl
  import cfs_pkg::*;
#(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         desc_i,
  input  logic         adv_i,
  output logic         wr_en_o,
  output logic         rd_en_o,
  output logic         clear_o,
  output logic         done_o,
  output logic         desc_o,
  output logic [W-1:0] idx_o
);
  phase_e       ph_q;
  logic [W-1:0] cnt_q;
  logic         desc_q;
  logic         last;

  assign clear_o = start_i && (ph_q == PH_IDLE || ph_q == PH_DONE);
  assign last    = (cnt_q == W'(N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      desc_q <= 1'b0;
    end else if (clear_o) begin
      ph_q   <= PH_WRITE;
      cnt_q  <= '0;
      desc_q <= desc_i;
    end else begin
      unique case (ph_q)
        PH_WRITE: begin
          cnt_q <= cnt_q + 1'b1;            // wraps to 0 for the read pass
          if (last) ph_q <= PH_READ;
        end
        PH_READ: if (adv_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) ph_q <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o = (ph_q == PH_WRITE);
  assign rd_en_o = (ph_q == PH_READ);
  assign done_o  = (ph_q == PH_DONE);
  assign desc_o  = desc_q;
  assign idx_o   = cnt_q;

  assert_read_follows_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> $past(wr_en_o));
  assert_done_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_en_o));
  assert_hold_on_dup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !adv_i && !start_i) |=> (rd_en_o && $stable(idx_o)));
  assert_order_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_o |=> $stable(desc_o));
  assert_done_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/counting_sorter.sv
module counting_sorter #(
  parameter int DATA_W = 3,
  parameter int CNT_W  = 10,
  localparam int N     = 1 << DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                descend_i,
  input  logic                in_valid_i,
  input  logic [DATA_W-1:0]   in_data_i,
  output logic                done_o,
  output logic [N*DATA_W-1:0] sorted_o
);
  logic              wr_en, rd_en, clear, desc, adv, emit;
  logic [DATA_W-1:0] idx;
  logic [N-1:0]      wr_hot, rd_hot;
  logic [CNT_W-1:0]  rd_cnt;
  logic [CNT_W:0]    dec_full;
  logic              one_det, borrow, more;

  cfs_ctrl #(.W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .desc_i(descend_i), .adv_i(adv),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .clear_o(clear), .done_o,
    .desc_o(desc), .idx_o(idx)
  );

  cfs_onehot_dec #(.W(DATA_W)) u_wr_dec (
    .en_i(in_valid_i && wr_en), .code_i(in_data_i), .hot_o(wr_hot)
  );

  cfs_onehot_dec #(.W(DATA_W)) u_rd_dec (
    .en_i(emit), .code_i(idx), .hot_o(rd_hot)
  );

  cfs_occ_bank #(.W(DATA_W), .CW(CNT_W)) u_bank (
    .clk_i, .rst_ni, .clear_i(clear), .inc_hot_i(wr_hot), .dec_hot_i(rd_hot),
    .dec_val_i(dec_full[CNT_W-1:0]), .rd_idx_i(idx), .rd_cnt_o(rd_cnt)
  );

  // one-detector plus decrementor borrow: count > 1 without a magnitude compare
  assign one_det  = (rd_cnt == CNT_W'(1));
  assign dec_full = {1'b0, rd_cnt} - 1'b1;
  assign borrow   = dec_full[CNT_W];
  assign more     = !one_det && !borrow;
  assign emit     = rd_en && (one_det || more);
  assign adv      = !more;

  cfs_sort_shreg #(.W(DATA_W)) u_out (
    .clk_i, .rst_ni, .clear_i(clear), .shift_i(emit), .desc_i(desc),
    .din_i(idx), .data_o(sorted_o)
  );

  assert_no_emit_outside_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |-> (rd_hot == '0));
  assert_single_emit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hot));
  assert_clear_drops_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (!done_o && sorted_o == '0));
endmodule

// File: tb/sim_counting_sorter.sv
`timescale 1ns/1ps
module sim_counting_sorter;
  localparam int W = 3;
  localparam int N = 1 << W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, descend_i = 1'b0, in_valid_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic done_o;
  logic [N*W-1:0] sorted_o;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  counting_sorter #(.DATA_W(W), .CNT_W(10)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .descend_i, .in_valid_i, .in_data_i,
    .done_o, .sorted_o
  );

  // vector: [31] order, [27:24] element count, [3*j +: 3] element j
  function automatic logic [31:0] mk(input bit d, input int m,
      input int a, input int b, input int c, input int e,
      input int f, input int g, input int h, input int k);
    logic [31:0] v;
    v = '0;
    v[31] = d; v[27:24] = 4'(m);
    v[2:0] = 3'(a); v[5:3] = 3'(b); v[8:6] = 3'(c); v[11:9] = 3'(e);
    v[14:12] = 3'(f); v[17:15] = 3'(g); v[20:18] = 3'(h); v[23:21] = 3'(k);
    return v;
  endfunction

  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    mk(0, 8, 5,1,3,1,7,0,3,3),
    mk(1, 8, 5,1,3,1,7,0,3,3),
    mk(0, 0, 0,0,0,0,0,0,0,0),
    mk(1, 8, 6,6,6,6,6,6,6,6),
    mk(0, 8, 6,6,6,6,6,6,6,6),
    mk(0, 8, 7,6,5,4,3,2,1,0),
    mk(1, 3, 2,2,4,0,0,0,0,0),
    mk(0, 1, 7,0,0,0,0,0,0,0),
    mk(1, 5, 0,0,7,0,7,0,0,0),
    mk(0, 6, 4,2,6,2,4,1,0,0)
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flip: toggle descend_i mid-sort; junk: offer elements while idle first
  task automatic run_case(input logic [31:0] v, input bit flip, input bit junk);
    int m, d, cyc;
    int s [N];
    logic [N*W-1:0] exp_arr, hold;
    m = int'(v[27:24]);
    for (int j = 0; j < N; j++) s[j] = int'(v[3*j +: 3]);
    for (int a = 0; a < m; a++)
      for (int b = 0; b + 1 < m - a; b++)
        if (s[b] > s[b+1]) begin int t = s[b]; s[b] = s[b+1]; s[b+1] = t; end
    d = 0;
    for (int j = 0; j < m; j++) if (j == 0 || s[j] != s[j-1]) d++;
    exp_arr = '0;
    for (int j = 0; j < m; j++)
      if (v[31]) exp_arr[j*W +: W] = W'(s[m-1-j]);
      else       exp_arr[(N-m+j)*W +: W] = W'(s[j]);

    @(negedge clk);
    if (junk) begin
      for (int j = 0; j < 4; j++) begin
        in_valid_i = 1'b1; in_data_i = W'(j + 3);
        @(negedge clk);
      end
      in_valid_i = 1'b0;
    end
    start_i = 1'b1; descend_i = v[31];
    @(posedge clk);
    cyc = 0;
    forever begin
      @(negedge clk);
      start_i = 1'b0;
      if (cyc == 0) check(!done_o, "R2", "done after start", 32'(done_o), 0);
      if (done_o) break;
      if (flip && cyc == 2) descend_i = ~v[31];
      if (cyc < m) begin in_valid_i = 1'b1; in_data_i = W'(s[(cyc*3) % m] * 0 + int'(v[3*cyc +: 3])); end
      else if (cyc < N) in_valid_i = 1'b0;
      else begin in_valid_i = 1'b1; in_data_i = W'(cyc); end  // ignored during read
      @(posedge clk);
      cyc++;
      if (cyc > 200) begin
        check(0, "R7", "timeout", 32'(cyc), 32'(2*N + m - d));
        in_valid_i = 1'b0;
        return;
      end
    end
    in_valid_i = 1'b0;
    check(cyc == 2*N + m - d, "R7", "done latency", 32'(cyc), 32'(2*N + m - d));
    check(sorted_o == exp_arr, v[31] ? "R5/R6" : "R4/R6", "array",
          32'(sorted_o), 32'(exp_arr));
    hold = sorted_o;
    repeat (3) @(negedge clk);
    check(done_o && sorted_o == hold, "R9", "hold", 32'(sorted_o), 32'(hold));
  endtask

  initial begin
    #5;
    check(!done_o, "R1", "done in reset", 32'(done_o), 0);
    check(sorted_o == '0, "R1", "array in reset", 32'(sorted_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!done_o && sorted_o == '0, "R1", "after reset", 32'(sorted_o), 0);

    for (int i = 0; i < NV; i++) run_case(VEC[i], 1'b0, 1'b0);

    // R3: elements offered while idle must not leak into an empty sort
    run_case(mk(0, 0, 0,0,0,0,0,0,0,0), 1'b0, 1'b1);
    // R3: idle junk, then a real set
    run_case(mk(1, 4, 1,5,5,2,0,0,0,0), 1'b0, 1'b1);
    // R8: order select changed mid-sort is ignored
    run_case(mk(0, 7, 3,0,6,3,1,2,6,0), 1'b1, 1'b0);
    run_case(mk(1, 7, 3,0,6,3,1,2,6,0), 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    check(0, "R7", "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule